// File: doc/BRIEF.md
# Gate Driver Protection Controller

This block is the clocked decision logic that sits between a host controller and one isolated power-switch gate driver. It takes a non-inverting command, an inverting command and an active-low shutdown input. Each of these is brought into the clock domain and filtered so that short glitches are dropped. The block then decides whether the gate may be driven on. It forces the gate off whenever a supply reports undervoltage, the internal link reports a failure, the shutdown input is low, or a desaturation fault has been latched.

A desaturation comparator output is trusted only after a blanking window has run out following each turn-on. Once the fault is latched, it holds the gate off and pulls the fault flag low. Only a shutdown pulse that stays low for a minimum number of cycles clears it, and the clear takes effect on that pulse's rising edge. The ready flag follows the supply and link health directly and needs no clearing. The Miller clamp enable is raised while the gate is off and the gate-below-threshold comparator reports true. Either input polarity mode works: for non-inverting use, tie the inverting input low; for inverting use, tie the non-inverting input high.

The controller is built around four states. `ST_OFF` is idle with the gate off. `ST_BLANK` drives the gate on while the blanking window counts. `ST_ON` drives the gate on with desaturation monitoring active. `ST_FAULT` is the latched desaturation fault. The transitions are:
- turn-on: `ST_OFF` to `ST_BLANK`;
- blank-expire: `ST_BLANK` to `ST_ON`;
- drop: `ST_BLANK` or `ST_ON` to `ST_OFF`;
- trip: `ST_ON` to `ST_FAULT`;
- clear: `ST_FAULT` to `ST_OFF`.

Top module: `gdrv_guard`

## Requirements
- R1: The gate command is high only while, after filtering, the non-inverting input is 1, the inverting input is 0, the shutdown input is 1, and all health inputs are 1. This holds in both the non-inverting mode (inverting input held 0) and the inverting mode (non-inverting input held 1).
- R2: Each of the two command inputs and the shutdown input passes through a two-flop synchroniser and a filter. The filter adopts a new level only after that level has stayed for FILT_CYC consecutive cycles, so any shorter pulse has no effect on the outputs.
- R3: While the filtered shutdown input is 0, the gate command is 0 from the next cycle on.
- R4: On each turn-on the blanking flag is 1 for exactly BLANK_CYC cycles while the gate is on. A desaturation report during that window is ignored.
- R5: A synchronised desaturation report while the gate is on after blanking sets the gate command to 0 and the fault flag to 0 on the next cycle. Both stay there whatever the command inputs do.
- R6: A latched fault is cleared on the rising edge of the filtered shutdown input only if that input was 0 for at least CLR_CYC cycles. A shorter low pulse leaves the fault flag at 0.
- R7: Any of input-side supply OK, output-side supply OK or link OK going to 0 forces the gate command to 0, at most three cycles after the input changes.
- R8: The ready flag equals input-side supply OK AND link OK AND output-side supply OK, where the output-side term is delayed by UV2_DLY further cycles. It needs no clearing.
- R9: The clamp enable is 1 exactly when the gate command is 0 and the synchronised gate-below-threshold input is 1.
- R10: During reset the gate command is 0, the blanking flag is 0, the fault flag is 1, the ready flag is 0 and the clamp enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_pos | input | 1 | Non-inverting gate command |
| cmd_neg | input | 1 | Inverting gate command |
| shut_n | input | 1 | Active-low shutdown; a long low pulse also clears a fault |
| desat_hit | input | 1 | Desaturation comparator output |
| gate_low | input | 1 | Gate voltage below clamp threshold |
| uv_in_ok | input | 1 | Input-side supply above undervoltage level |
| uv_out_ok | input | 1 | Output-side supply above undervoltage level |
| link_ok | input | 1 | Internal signal link fault-free |
| gate_on | output | 1 | Gate drive command |
| clamp_en | output | 1 | Miller clamp enable |
| fault_n | output | 1 | Desaturation fault flag, low when latched |
| ready | output | 1 | Supplies and link healthy |
| blank_win | output | 1 | Blanking window in progress |

## Verification
The assertions assume that every external input is asynchronous. They also assume that the synchronisers are the only path into the state logic, so each property relates values one register stage apart. The stimulus changes inputs only between clock edges. It holds the health inputs high for most of the run, so that the blanking, trip and clear paths are reached. It drops each health input separately. It uses low pulses on the shutdown input both shorter and longer than the clear limit, and glitches on the command inputs both shorter and longer than the filter length. A behavioural model built from the requirements is compared with every output on every clock.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_BLANK = 2'd1,
        ST_ON    = 2'd2,
        ST_FAULT = 2'd3
    } gdrv_state_e;

    // bit positions of the synchronised input vector
    localparam int IX_POS   = 0;
    localparam int IX_NEG   = 1;
    localparam int IX_SHUT  = 2;
    localparam int IX_DESAT = 3;
    localparam int IX_GLOW  = 4;
    localparam int IX_UVIN  = 5;
    localparam int IX_UVOUT = 6;
    localparam int IX_LINK  = 7;
    localparam int N_SYNC   = 8;

    // safe values during reset: inverting input high, gate-low true
    localparam logic [N_SYNC-1:0] SYNC_RST = 8'b0001_0010;

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            meta   <= d_async;
            d_sync <= meta;
        end
    end
endmodule

// File: rtl/gdrv_deglitch.sv
module gdrv_deglitch #(
    parameter int FILT_CYC = 8,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int            CW   = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= RST_VAL;
            run  <= '0;
        end else if (din == dout) begin
            run <= '0;
        end else if (run == LAST) begin
            dout <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R2
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(din) == dout));

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(din) == $past(dout)) |-> $stable(dout));
endmodule

// File: rtl/gdrv_fsm.sv
module gdrv_fsm
    import gdrv_pkg::*;
#(
    parameter int BLANK_CYC = 16,
    parameter int CLR_CYC   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic health,
    input  logic desat,
    input  logic shut_ok,
    output logic gate_on,
    output logic blank_win,
    output logic fault_n
);
    localparam int            BW     = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] B_LAST = BW'(BLANK_CYC - 1);
    localparam int            LW     = $clog2(CLR_CYC + 1);
    localparam logic [LW-1:0] L_MAX  = LW'(CLR_CYC);

    gdrv_state_e   state, state_nx;
    logic [BW-1:0] bcnt;
    logic [LW-1:0] low_cnt;
    logic          shut_prev;
    logic          run_ok;
    logic          clear_ok;

    assign run_ok   = health && want;
    assign clear_ok = shut_ok && !shut_prev && (low_cnt >= L_MAX);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (run_ok) state_nx = ST_BLANK;
            ST_BLANK: begin
                if (!run_ok)            state_nx = ST_OFF;
                else if (bcnt == B_LAST) state_nx = ST_ON;
            end
            ST_ON: begin
                if (desat)        state_nx = ST_FAULT;
                else if (!run_ok) state_nx = ST_OFF;
            end
            ST_FAULT: if (clear_ok) state_nx = ST_OFF;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            bcnt      <= '0;
            low_cnt   <= '0;
            shut_prev <= 1'b0;
        end else begin
            state     <= state_nx;
            bcnt      <= (state == ST_BLANK && state_nx == ST_BLANK) ? bcnt + 1'b1 : '0;
            shut_prev <= shut_ok;
            if (shut_ok)
                low_cnt <= '0;
            else if (low_cnt != L_MAX)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // outputs from state
    always_comb begin
        gate_on   = 1'b0;
        blank_win = 1'b0;
        fault_n   = 1'b1;
        unique case (state)
            ST_OFF:   ;
            ST_BLANK: begin gate_on = 1'b1; blank_win = 1'b1; end
            ST_ON:    gate_on = 1'b1;
            ST_FAULT: fault_n = 1'b0;
        endcase
    end

    // R1
    gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> $past(run_ok));

    // R3
    shut_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_ok |=> !gate_on);

    // R4
    blank_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_win |=> fault_n);

    // R6
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !clear_ok) |=> !fault_n);

    // R5
    trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !blank_win && desat) |=> (!fault_n && !gate_on));
endmodule

// File: rtl/gdrv_guard.sv
module gdrv_guard
    import gdrv_pkg::*;
#(
    parameter int FILT_CYC  = 8,
    parameter int BLANK_CYC = 16,
    parameter int CLR_CYC   = 64,
    parameter int UV2_DLY   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_pos,
    input  logic cmd_neg,
    input  logic shut_n,
    input  logic desat_hit,
    input  logic gate_low,
    input  logic uv_in_ok,
    input  logic uv_out_ok,
    input  logic link_ok,
    output logic gate_on,
    output logic clamp_en,
    output logic fault_n,
    output logic ready,
    output logic blank_win
);
    localparam int N_FILT = 3;

    logic [N_SYNC-1:0] raw_v, syn_v;
    logic [N_FILT-1:0] filt_v;
    logic              uv_out_late;
    logic              health, want;

    always_comb begin
        raw_v           = '0;
        raw_v[IX_POS]   = cmd_pos;
        raw_v[IX_NEG]   = cmd_neg;
        raw_v[IX_SHUT]  = shut_n;
        raw_v[IX_DESAT] = desat_hit;
        raw_v[IX_GLOW]  = gate_low;
        raw_v[IX_UVIN]  = uv_in_ok;
        raw_v[IX_UVOUT] = uv_out_ok;
        raw_v[IX_LINK]  = link_ok;
    end

    gdrv_sync #(.W(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_v),
        .d_sync  (syn_v)
    );

    // the three command inputs occupy the low sync bits
    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        gdrv_deglitch #(.FILT_CYC(FILT_CYC), .RST_VAL(SYNC_RST[g])) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (syn_v[g]),
            .dout  (filt_v[g])
        );
    end

    if (UV2_DLY == 0) begin : g_nodly
        assign uv_out_late = syn_v[IX_UVOUT];
    end else begin : g_dly
        logic [UV2_DLY-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[UV2_DLY-2 >= 0 ? UV2_DLY-2 : 0 : 0], syn_v[IX_UVOUT]};
        end
        assign uv_out_late = chain[UV2_DLY-1];
    end

    assign health = syn_v[IX_UVIN] & syn_v[IX_UVOUT] & syn_v[IX_LINK];
    assign want   = filt_v[IX_POS] & ~filt_v[IX_NEG] & filt_v[IX_SHUT];

    gdrv_fsm #(.BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .health    (health),
        .desat     (syn_v[IX_DESAT]),
        .shut_ok   (filt_v[IX_SHUT]),
        .gate_on   (gate_on),
        .blank_win (blank_win),
        .fault_n   (fault_n)
    );

    assign ready    = syn_v[IX_UVIN] & syn_v[IX_LINK] & uv_out_late;
    assign clamp_en = ~gate_on & syn_v[IX_GLOW];

    // R7
    health_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !health |=> !gate_on);

    // R8
    ready_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uv_in_ok) == 1'b0 && $past(uv_in_ok, 2) == 1'b0 && $past(rst_n, 2)) |-> !ready);
endmodule

// File: tb/gdrv_guard_bench.sv
`timescale 1ns/1ps
module gdrv_guard_bench;
    localparam int FILT  = 8;
    localparam int BLANK = 16;
    localparam int CLR   = 64;
    localparam int UDLY  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_pos = 1'b0, cmd_neg = 1'b0, shut_n = 1'b1, desat_hit = 1'b0;
    logic gate_low = 1'b1, uv_in_ok = 1'b1, uv_out_ok = 1'b1, link_ok = 1'b1;
    logic gate_on, clamp_en, fault_n, ready, blank_win;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gdrv_guard #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .CLR_CYC(CLR), .UV2_DLY(UDLY)) u_gdrv_guard (
        .clk(clk), .rst_n(rst_n), .cmd_pos(cmd_pos), .cmd_neg(cmd_neg), .shut_n(shut_n),
        .desat_hit(desat_hit), .gate_low(gate_low), .uv_in_ok(uv_in_ok), .uv_out_ok(uv_out_ok),
        .link_ok(link_ok), .gate_on(gate_on), .clamp_en(clamp_en), .fault_n(fault_n),
        .ready(ready), .blank_win(blank_win)
    );

    // ---------------- behavioural reference model ----------------
    // raw inputs in order: pos, neg, shut, desat, glow, uvin, uvout, link
    int s1 [8];
    int s2 [8];
    int filt [3];
    int run  [3];
    int uq [$];
    int mode;       // 0 idle, 1 blanking, 2 driving, 3 tripped
    int bleft;
    int lowlen;
    int shut_was;

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin
            s1[i] = (i == 1 || i == 4) ? 1 : 0;
            s2[i] = s1[i];
        end
        filt[0] = 0; filt[1] = 1; filt[2] = 0;
        for (int i = 0; i < 3; i++) run[i] = 0;
        uq.delete();
        for (int i = 0; i < UDLY; i++) uq.push_back(0);
        mode = 0; bleft = 0; lowlen = 0; shut_was = 0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int ok, go, clr;
            ok  = s2[5] & s2[6] & s2[7];
            go  = filt[0] & (1 - filt[1]) & filt[2];
            clr = (filt[2] == 1 && shut_was == 0 && lowlen >= CLR) ? 1 : 0;
            case (mode)
                0: if (ok && go) begin mode = 1; bleft = BLANK; end
                1: begin
                    bleft--;
                    if (!(ok && go)) mode = 0;
                    else if (bleft == 0) mode = 2;
                end
                2: if (s2[3]) mode = 3; else if (!(ok && go)) mode = 0;
                default: if (clr) mode = 0;
            endcase
            if (filt[2]) lowlen = 0; else if (lowlen < CLR) lowlen++;
            shut_was = filt[2];
            for (int i = 0; i < 3; i++) begin
                if (s2[i] == filt[i]) run[i] = 0;
                else if (run[i] == FILT - 1) begin filt[i] = s2[i]; run[i] = 0; end
                else run[i]++;
            end
            uq.push_back(s2[6]);
            void'(uq.pop_front());
            for (int i = 0; i < 8; i++) s2[i] = s1[i];
            s1[0] = cmd_pos; s1[1] = cmd_neg; s1[2] = shut_n; s1[3] = desat_hit;
            s1[4] = gate_low; s1[5] = uv_in_ok; s1[6] = uv_out_ok; s1[7] = link_ok;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int eg, eb, ef, er, ec;
            bit bad;
            eg = (mode == 1 || mode == 2) ? 1 : 0;
            eb = (mode == 1) ? 1 : 0;
            ef = (mode == 3) ? 0 : 1;
            er = s2[5] & s2[7] & uq[0];
            ec = (1 - eg) & s2[4];
            bad = 0;
            checks++;
            if (gate_on !== eg[0])   begin bad = 1; $display("FAIL R1 gate_on act=%0b exp=%0d t=%0t", gate_on, eg, $time); end
            if (blank_win !== eb[0]) begin bad = 1; $display("FAIL R4 blank_win act=%0b exp=%0d t=%0t", blank_win, eb, $time); end
            if (fault_n !== ef[0])   begin bad = 1; $display("FAIL R5 fault_n act=%0b exp=%0d t=%0t", fault_n, ef, $time); end
            if (ready !== er[0])     begin bad = 1; $display("FAIL R8 ready act=%0b exp=%0d t=%0t", ready, er, $time); end
            if (clamp_en !== ec[0])  begin bad = 1; $display("FAIL R9 clamp_en act=%0b exp=%0d t=%0t", clamp_en, ec, $time); end
            if (bad) fails++;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        wait_cyc(4);
        // R10 reset state
        chk("R10 gate_on", gate_on, 1'b0);
        chk("R10 blank_win", blank_win, 1'b0);
        chk("R10 fault_n", fault_n, 1'b1);
        chk("R10 ready", ready, 1'b0);
        chk("R10 clamp_en", clamp_en, 1'b1);
        rst_n = 1'b1;
        wait_cyc(20);
        chk("R8 ready up", ready, 1'b1);

        // R1 non-inverting mode, R4 desat ignored while blanking
        cmd_pos = 1'b1;
        wait_cyc(14);
        chk("R4 blank_win", blank_win, 1'b1);
        desat_hit = 1'b1;
        wait_cyc(3);
        desat_hit = 1'b0;
        wait_cyc(25);
        chk("R4 fault_n", fault_n, 1'b1);
        chk("R1 gate on", gate_on, 1'b1);
        chk("R9 clamp off", clamp_en, 1'b0);

        // R2 short low glitch on pos ignored
        cmd_pos = 1'b0;
        wait_cyc(FILT / 2);
        cmd_pos = 1'b1;
        wait_cyc(15);
        chk("R2 glitch ignored", gate_on, 1'b1);
        cmd_pos = 1'b0;
        wait_cyc(15);
        chk("R1 gate off", gate_on, 1'b0);
        chk("R9 clamp on", clamp_en, 1'b1);
        gate_low = 1'b0;
        wait_cyc(4);
        chk("R9 clamp waits", clamp_en, 1'b0);
        gate_low = 1'b1;

        // R1 inverting mode
        cmd_pos = 1'b1; cmd_neg = 1'b1;
        wait_cyc(15);
        chk("R1 inv idle", gate_on, 1'b0);
        cmd_neg = 1'b0;
        wait_cyc(3);
        cmd_neg = 1'b1;
        wait_cyc(15);
        chk("R2 neg glitch", gate_on, 1'b0);
        cmd_neg = 1'b0;
        wait_cyc(15);
        chk("R1 inv on", gate_on, 1'b1);

        // R3 shutdown
        shut_n = 1'b0;
        wait_cyc(4);
        shut_n = 1'b1;
        wait_cyc(15);
        chk("R2 shut glitch", gate_on, 1'b1);
        shut_n = 1'b0;
        wait_cyc(15);
        chk("R3 shut off", gate_on, 1'b0);
        shut_n = 1'b1;
        wait_cyc(40);
        chk("R3 resume", gate_on, 1'b1);

        // R5 trip after blanking
        desat_hit = 1'b1;
        wait_cyc(2);
        desat_hit = 1'b0;
        wait_cyc(6);
        chk("R5 tripped", fault_n, 1'b0);
        chk("R5 gate off", gate_on, 1'b0);
        cmd_neg = 1'b1;
        wait_cyc(15);
        cmd_neg = 1'b0;
        wait_cyc(40);
        chk("R5 stays off", gate_on, 1'b0);

        // R6 short clear pulse ignored, long one clears
        shut_n = 1'b0;
        wait_cyc(20);
        shut_n = 1'b1;
        wait_cyc(20);
        chk("R6 short pulse", fault_n, 1'b0);
        shut_n = 1'b0;
        wait_cyc(CLR + 30);
        shut_n = 1'b1;
        wait_cyc(15);
        chk("R6 cleared", fault_n, 1'b1);
        wait_cyc(30);
        chk("R6 runs again", gate_on, 1'b1);

        // R7 / R8 health inputs
        uv_in_ok = 1'b0;
        wait_cyc(4);
        chk("R7 uv_in off", gate_on, 1'b0);
        chk("R8 ready uv_in", ready, 1'b0);
        uv_in_ok = 1'b1;
        wait_cyc(30);
        link_ok = 1'b0;
        wait_cyc(4);
        chk("R7 link off", gate_on, 1'b0);
        chk("R8 ready link", ready, 1'b0);
        link_ok = 1'b1;
        wait_cyc(30);
        uv_out_ok = 1'b0;
        wait_cyc(4);
        chk("R7 uv_out off", gate_on, 1'b0);
        chk("R8 ready delayed", ready, 1'b1);
        wait_cyc(UDLY + 2);
        chk("R8 ready uv_out", ready, 1'b0);
        uv_out_ok = 1'b1;
        wait_cyc(30);

        // mixed stimulus, checked by the model every clock (R1..R9)
        for (int seg = 0; seg < 400; seg++) begin
            int r;
            r = $urandom_range(0, 99);
            cmd_pos   = $urandom_range(0, 3) != 0;
            cmd_neg   = $urandom_range(0, 3) == 0;
            gate_low  = $urandom_range(0, 1);
            desat_hit = (r < 8);
            uv_in_ok  = (r != 10);
            uv_out_ok = (r != 11);
            link_ok   = (r != 12);
            shut_n    = !(r >= 90);
            if (r >= 96) wait_cyc(CLR + 20);
            else         wait_cyc($urandom_range(1, 40));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule